// File: doc/BRIEF.md
# Byte-Lane Static RAM Array

A clocked model of a 16-bit-wide static memory that keeps the control set of an asynchronous SRAM: an 18-bit word address, a pair of chip selects (one active low, one active high), an active-low write enable, an active-low output enable and a separate active-low select for each byte of the word. The shared data bus of such a part is split into a write-data input, a registered read-data output and a per-byte output-enable vector. A wrapper can combine these three into a tri-state bus.

All decisions are taken on the rising clock edge. A write stores the selected bytes at that edge. A read returns the selected bytes, together with their output enables, one clock after the address is sampled. Accesses may follow one another on every cycle. The full organisation is 262,144 words. For simulation the parameter `MEM_AW` reduces the number of stored words to 2^MEM_AW, and address bits above `MEM_AW` are then ignored. Each byte lane is its own memory, so it maps onto block RAM with a byte write enable.

Top module: `sram_lane_array`

## Requirements
- R1: The array is selected only when `cs_lo_n` is 0 and `cs_hi` is 1. In any other chip-select state no location is changed, and `lane_oe` is 2'b00 one clock later.
- R2: When `ub_n` and `lb_n` are both 1, no location is changed, whatever the other controls are, and `lane_oe` is 2'b00 one clock later.
- R3: A read is selected, `we_n`=1, `oe_n`=0. One clock later, `lane_oe[i]` is 1 exactly for the lanes whose byte select was 0, and those lanes of `rdata` hold the stored bytes of the sampled address.
- R4: Lane 0 is bits 7:0, controlled by `lb_n` and reported on `lane_oe[0]`. Lane 1 is bits 15:8, controlled by `ub_n` and reported on `lane_oe[1]`. Lower-only, upper-only and full-word accesses are all supported.
- R5: A write is selected with `we_n`=0, for either level of `oe_n`. At the clock edge it stores the `wdata` lanes whose byte select is 0 and leaves the other lane of that word unchanged.
- R6: No lane is enabled during a write: `lane_oe` is 2'b00 one clock after a write.
- R7: Output disable is selected, `we_n`=1, `oe_n`=1. It stores nothing, and `lane_oe` is 2'b00 one clock later.
- R8: Accesses need no gap between them. A read in the cycle right after a write to the same address returns the new data, and reads on consecutive cycles each deliver their data one clock later.
- R9: While `rst` is 1, `lane_oe` is 2'b00 one clock later. The contents of the array are not defined by reset.
- R10: Only address bits `MEM_AW-1:0` select a word. With `MEM_AW`=10, addresses that differ only in bits 17:10 reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling is on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 18 | Word address |
| cs_lo_n | input | 1 | Chip select, active low |
| cs_hi | input | 1 | Chip select, active high |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ub_n | input | 1 | Upper byte (bits 15:8) select, active low |
| lb_n | input | 1 | Lower byte (bits 7:0) select, active low |
| wdata | input | 16 | Data to store |
| rdata | output | 16 | Registered read data |
| lane_oe | output | 2 | Registered per-lane drive enable, bit 0 lower, bit 1 upper |

## Verification
Every cycle, the assertions check how the control pins map onto `lane_oe` one clock later: quiet in standby, when no byte is selected, during a write, during output disable and after reset, and equal to the inverted byte selects on a read. They also check that a lane memory is never asked to read and write in the same cycle. Whether the right bytes were stored, whether the unselected lane and blocked writes left a word untouched, and whether aliased addresses reach one word depend on the contents of the array. Only the bench can show these, through its write-then-read sweeps compared against its own model of the memory.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  // Access kind decoded from the control pins for one clock cycle.
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,  // standby: deselected or no byte lane chosen
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_QUIET = 2'd3   // selected, neither writing nor driving
  } acc_op_e;

  localparam int LANE_BITS = 8;

endpackage

// File: rtl/sram_ctrl_decode.sv
module sram_ctrl_decode
  import sram_lane_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             cs_lo_n,
  input  logic             cs_hi,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] bsel_n,
  output acc_op_e          op,
  output logic [LANES-1:0] lane_mask
);

  logic chip_on;
  logic any_lane;

  always_comb begin
    chip_on   = !cs_lo_n && cs_hi;
    lane_mask = ~bsel_n;
    any_lane  = |lane_mask;
    op        = OP_IDLE;
    if (chip_on && any_lane) begin
      // write enable wins over output enable
      if (!we_n)      op = OP_WRITE;
      else if (!oe_n) op = OP_READ;
      else            op = OP_QUIET;
    end
  end

endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
  parameter int AW = 10,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] idx,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] store [DEPTH];
  logic [W-1:0] rd_q;

  // single port, read-first, no reset on the array: block RAM shape
  always_ff @(posedge clk) begin
    if (wr_en) store[idx] <= wdata;
    if (rd_en) rd_q <= store[idx];
  end

  assign rdata = rd_q;

  // Write and read never share a cycle on one lane (R5 / R6 separation)
  assert_no_rw_collision_R6: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !wr_en);

endmodule

// File: rtl/sram_lane_oe_reg.sv
module sram_lane_oe_reg
  import sram_lane_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  acc_op_e          op,
  input  logic [LANES-1:0] lane_mask,
  output logic [LANES-1:0] lane_oe
);

  logic [LANES-1:0] oe_q;

  always_ff @(posedge clk) begin
    if (rst)                oe_q <= '0;
    else if (op == OP_READ) oe_q <= lane_mask;
    else                    oe_q <= '0;
  end

  assign lane_oe = oe_q;

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs_lo_n,
  input  logic              cs_hi,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        lane_oe
);

  localparam int LANES  = 2;
  localparam int LANE_W = DATA_W / LANES;

  acc_op_e          op;
  logic [LANES-1:0] lane_mask;
  logic [MEM_AW-1:0] word_idx;

  assign word_idx = addr[MEM_AW-1:0];

  sram_ctrl_decode #(.LANES(LANES)) decode_i (
    .cs_lo_n  (cs_lo_n),
    .cs_hi    (cs_hi),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .bsel_n   ({ub_n, lb_n}),
    .op       (op),
    .lane_mask(lane_mask)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic wr_g;
    logic rd_g;
    assign wr_g = (op == OP_WRITE) && lane_mask[g];
    assign rd_g = (op == OP_READ)  && lane_mask[g];

    sram_lane_bank #(.AW(MEM_AW), .W(LANE_W)) bank_i (
      .clk  (clk),
      .rst  (rst),
      .wr_en(wr_g),
      .rd_en(rd_g),
      .idx  (word_idx),
      .wdata(wdata[g*LANE_W +: LANE_W]),
      .rdata(rdata[g*LANE_W +: LANE_W])
    );
  end

  sram_lane_oe_reg #(.LANES(LANES)) oe_i (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .lane_mask(lane_mask),
    .lane_oe  (lane_oe)
  );

  // Port-level checks of the control decode, one clock after sampling
  assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (cs_lo_n || !cs_hi) |=> (lane_oe == 2'b00));

  assert_no_byte_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (ub_n && lb_n) |=> (lane_oe == 2'b00));

  assert_read_lanes_R3: assert property (@(posedge clk) disable iff (rst)
    (!cs_lo_n && cs_hi && we_n && !oe_n) |=> (lane_oe == ~$past({ub_n, lb_n})));

  assert_write_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (!cs_lo_n && cs_hi && !we_n) |=> (lane_oe == 2'b00));

  assert_disable_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (!cs_lo_n && cs_hi && we_n && oe_n) |=> (lane_oe == 2'b00));

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (lane_oe == 2'b00));

endmodule

// File: tb/sram_lane_array_tb_top.sv
module sram_lane_array_tb_top;

  localparam int AW    = 18;
  localparam int DW    = 16;
  localparam int MAW   = 10;
  localparam int DEPTH = 1 << MAW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          cs_lo_n = 1'b1, cs_hi = 1'b0, we_n = 1'b1, oe_n = 1'b1;
  logic          ub_n = 1'b1, lb_n = 1'b1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [1:0]    lane_oe;

  sram_lane_array #(.ADDR_W(AW), .DATA_W(DW), .MEM_AW(MAW)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .cs_lo_n(cs_lo_n), .cs_hi(cs_hi),
    .we_n(we_n), .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n),
    .wdata(wdata), .rdata(rdata), .lane_oe(lane_oe)
  );

  logic [DW-1:0] model [DEPTH];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'((a * 40503) + salt * 7919 + 16'h5A5A);
  endfunction

  // drive at negedge, sample 2 ns after the following rising edge
  task automatic step(input logic [AW-1:0] a, input logic c1n, input logic c2,
                      input logic wen, input logic oen, input logic ubn,
                      input logic lbn, input logic [DW-1:0] wd);
    @(negedge clk);
    addr = a; cs_lo_n = c1n; cs_hi = c2; we_n = wen; oe_n = oen;
    ub_n = ubn; lb_n = lbn; wdata = wd;
    @(posedge clk);
    #2;
  endtask

  task automatic do_write(input int a, input logic ubn, input logic lbn,
                          input logic oen, input logic [DW-1:0] wd);
    int i;
    i = a % DEPTH;
    step(AW'(a), 1'b0, 1'b1, 1'b0, oen, ubn, lbn, wd);
    if (!lbn) model[i][7:0]  = wd[7:0];
    if (!ubn) model[i][15:8] = wd[15:8];
    chk("R6 lane_oe after write", 32'(lane_oe), 32'd0);
  endtask

  task automatic do_read(input int a, input logic ubn, input logic lbn, input string tag);
    int i;
    i = a % DEPTH;
    step(AW'(a), 1'b0, 1'b1, 1'b1, 1'b0, ubn, lbn, '0);
    chk({tag, " R3 lane_oe"}, 32'(lane_oe), 32'({~ubn, ~lbn}));
    if (!lbn) chk({tag, " R4 lower lane"}, 32'(rdata[7:0]),  32'(model[i][7:0]));
    if (!ubn) chk({tag, " R4 upper lane"}, 32'(rdata[15:8]), 32'(model[i][15:8]));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9: reset clears the lane enables
    repeat (3) step('0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
    chk("R9 lane_oe in reset", 32'(lane_oe), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    step('0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0);
    chk("R9 lane_oe after reset", 32'(lane_oe), 32'd0);

    // R5: full-word write sweep, then full-word read sweep (R3)
    for (int a = 0; a < DEPTH; a++) do_write(a, 1'b0, 1'b0, 1'b1, pat(a, 1));
    for (int a = 0; a < DEPTH; a++) do_read(a, 1'b0, 1'b0, "R3 full sweep");

    // R4/R5: lower-only writes leave upper lane unchanged
    for (int a = 0; a < 256; a++) do_write(a, 1'b1, 1'b0, 1'b1, pat(a, 2));
    for (int a = 0; a < 256; a++) begin
      do_read(a, 1'b1, 1'b0, "R4 lower-only");
      do_read(a, 1'b0, 1'b1, "R5 upper kept");
    end

    // R4/R5: upper-only writes with oe_n low (write wins)
    for (int a = 256; a < 512; a++) do_write(a, 1'b0, 1'b1, 1'b0, pat(a, 3));
    for (int a = 256; a < 512; a++) do_read(a, 1'b0, 1'b0, "R5 upper-only");

    // R1, R2, R7: blocked writes and quiet cycles leave contents unchanged
    for (int a = 600; a < 632; a++) begin
      step(AW'(a), 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, ~model[a]);
      chk("R1 cs_lo_n high lane_oe", 32'(lane_oe), 32'd0);
      step(AW'(a), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, ~model[a]);
      chk("R1 cs_hi low lane_oe", 32'(lane_oe), 32'd0);
      step(AW'(a), 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
      chk("R1 deselected read lane_oe", 32'(lane_oe), 32'd0);
      step(AW'(a), 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, ~model[a]);
      chk("R2 no byte write lane_oe", 32'(lane_oe), 32'd0);
      step(AW'(a), 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, '0);
      chk("R2 no byte read lane_oe", 32'(lane_oe), 32'd0);
      step(AW'(a), 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, ~model[a]);
      chk("R7 output disable lane_oe", 32'(lane_oe), 32'd0);
      do_read(a, 1'b0, 1'b0, "R1 R2 R7 contents kept");
    end

    // R8: write then read on the next cycle, and a burst of reads
    for (int a = 700; a < 764; a++) begin
      do_write(a, 1'b0, 1'b0, 1'b1, pat(a, 4));
      do_read(a, 1'b0, 1'b0, "R8 read after write");
    end
    for (int a = 700; a < 764; a++) do_read(a, 1'b0, 1'b0, "R8 read burst");

    // R10: upper address bits are ignored
    for (int k = 1; k < 8; k++) begin
      do_write(k * 37 + (k << MAW), 1'b0, 1'b0, 1'b1, pat(k, 5));
      do_read(k * 37, 1'b0, 1'b0, "R10 alias");
    end

    step('0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0);
    chk("R1 idle lane_oe", 32'(lane_oe), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule